// File: doc/BRIEF.md
# Backlight PWM Generator with Prescaler

This block drives one pulse-width-modulated output, typically used to dim a display backlight. A counter runs through 256 steps per period; the output is in its active state while the counter is below an 8-bit compare value and inactive for the rest. The step rate is the selected source rate divided by a power of two from 1 to 64. The source is either a slow reference, delivered as a one-cycle tick on `slow_tick_i`, or the block clock itself.

Software configures the block through a small register port. One configuration register holds the compare value, the prescaler, the output polarity and the source select. Two write-only strobe addresses start and stop the generator. A read-only status bit reports whether the generator is running. A start or stop request crosses a two-stage synchroniser clocked by source ticks. A stop takes effect only at the end of a period. Software therefore polls the status bit after each request. New compare and prescaler values are held until the next period begins.

Top module: `bl_pwm`

## Requirements
- R1: The register map is: address 0 is the configuration register, 1 the start strobe, 2 the stop strobe, and 3 the status register. In the configuration register, prescaler is bits [2:0], polarity bit 4, source select bit 7 and compare value bits [15:8]. Other bits read 0. The reset value is 0x0010 (normal polarity, everything else zero). Address 3 returns the running flag in bit 0. Addresses 1 and 2 read 0.
- R2: A prescaler write of 7 is stored as 6; a prescaler in use never exceeds 6.
- R3: A period lasts 256 x 2^PS source ticks. The active state lasts CVAL x 2^PS source ticks as one contiguous burst at the start of the period.
- R4: Source select 1 makes every clock cycle a tick. Source select 0 counts only cycles in which `slow_tick_i` is high, and the start handshake also advances only on those ticks.
- R5: Polarity 1 drives `pwm_o` high while active. Polarity 0 drives it low while active and high otherwise.
- R6: Writing address 1 with bit 0 set requests a start. Writing 0 there has no effect. Status becomes 1 no earlier than the second source tick after the write, and the counter starts at 0.
- R7: Writing address 2 with bit 0 set requests a stop. Status stays 1 until the end of the current period and then reads 0.
- R8: While stopped, `pwm_o` holds the inactive level given by the current polarity and the counter is held at 0.
- R9: Compare and prescaler writes made while running take effect only at the next period start; the running period completes with the old values.
- R10: Compare value 0 keeps the output inactive for the whole period. Compare value 255 gives 255 active steps and one inactive step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock; also the fast tick source |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slow_tick_i | input | 1 | One-cycle tick from the slow reference |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i` (combinational) |
| pwm_o | output | 1 | PWM output |

## Verification
Assertions check the following on every cycle:
- the prescaler in use stays within its cap;
- the output sits at its inactive level with the counter at zero whenever the generator is stopped;
- a zero compare never lets the output go active;
- the held compare and prescaler values change only at a period end;
- the status bit falls only on a period end and rises with the counter at zero.

The bench scenarios show what needs whole periods of observation. It measures both the count of high cycles and the longest high burst over full periods, for several compare values, prescalers, polarities and both sources. It runs a first period measured from the start point while the compare value is rewritten partway through. It also times the start delay, which differs between sources, and confirms that a stop request is not honoured before the period ends.

// File: rtl/bl_pwm_pkg.sv
`timescale 1ns/1ps
package bl_pwm_pkg;
  localparam int unsigned ADDR_W = 2;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned CNT_W  = 8;
  localparam int unsigned PS_W   = 3;
  localparam int unsigned PS_MAX = 6;

  typedef enum logic [ADDR_W-1:0] {
    REG_CFG  = 2'd0,
    REG_ON   = 2'd1,
    REG_OFF  = 2'd2,
    REG_STAT = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic [CNT_W-1:0] cval;
    logic             fast;
    logic [1:0]       rsv_hi;
    logic             pol;
    logic             rsv_lo;
    logic [PS_W-1:0]  ps;
  } cfg_t;
endpackage

// File: rtl/bl_pwm_regs.sv
`timescale 1ns/1ps
module bl_pwm_regs
  import bl_pwm_pkg::*;
#(
  parameter int unsigned PS_LIMIT = PS_MAX
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              run_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [CNT_W-1:0]  cval_o,
  output logic [PS_W-1:0]   ps_o,
  output logic              pol_o,
  output logic              fast_o,
  output logic              on_o,
  output logic              off_o
);
  localparam logic [PS_W-1:0] PS_CAP = PS_W'(PS_LIMIT);

  cfg_t      cfg_q;
  reg_addr_e addr;
  logic      unused_wbits;

  assign addr         = reg_addr_e'(addr_i);
  assign unused_wbits = ^{wdata_i[6:5], wdata_i[3]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '{cval: '0, fast: 1'b0, rsv_hi: '0, pol: 1'b1, rsv_lo: 1'b0, ps: '0};
    end else if (wr_en_i && addr == REG_CFG) begin
      cfg_q.cval <= wdata_i[15:8];
      cfg_q.fast <= wdata_i[7];
      cfg_q.pol  <= wdata_i[4];
      cfg_q.ps   <= (wdata_i[2:0] > PS_CAP) ? PS_CAP : wdata_i[2:0];
    end
  end

  assign on_o  = wr_en_i && addr == REG_ON  && wdata_i[0];
  assign off_o = wr_en_i && addr == REG_OFF && wdata_i[0];

  always_comb begin
    unique case (addr)
      REG_CFG:  rdata_o = cfg_q;
      REG_STAT: rdata_o = {{(DATA_W-1){1'b0}}, run_i};
      default:  rdata_o = '0;
    endcase
  end

  assign cval_o = cfg_q.cval;
  assign ps_o   = cfg_q.ps;
  assign pol_o  = cfg_q.pol;
  assign fast_o = cfg_q.fast;
endmodule

// File: rtl/bl_pwm_ctrl.sv
`timescale 1ns/1ps
module bl_pwm_ctrl #(
  parameter int unsigned SYNC_N = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic on_i,
  input  logic off_i,
  input  logic period_end_i,
  output logic run_o,
  output logic start_o
);
  logic              want_q;
  logic [SYNC_N-1:0] sync_q;
  logic              want_s;
  logic              run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    want_q <= 1'b0;
    else if (off_i) want_q <= 1'b0;
    else if (on_i)  want_q <= 1'b1;
  end

  // request crosses into the tick domain
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sync_q <= '0;
    else if (tick_i) sync_q <= {sync_q[SYNC_N-2:0], want_q};
  end

  assign want_s  = sync_q[SYNC_N-1];
  assign start_o = tick_i && want_s && !run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                run_q <= 1'b0;
    else if (start_o)                           run_q <= 1'b1;
    else if (run_q && !want_s && period_end_i)  run_q <= 1'b0;
  end

  assign run_o = run_q;
endmodule

// File: rtl/bl_pwm_core.sv
`timescale 1ns/1ps
module bl_pwm_core #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned PS_W  = 3,
  parameter int unsigned PRE_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             start_i,
  input  logic [CNT_W-1:0] cval_i,
  input  logic [PS_W-1:0]  ps_i,
  input  logic             pol_i,
  output logic             pwm_o,
  output logic             period_end_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cval_act_o,
  output logic [PS_W-1:0]  ps_act_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] cval_act;
  logic [PS_W-1:0]  ps_act;
  logic [PS_W-1:0]  shift;
  logic [PRE_W-1:0] pre_mask;
  logic             step;
  logic             active;

  assign shift        = PS_W'(PRE_W) - ps_act;
  assign pre_mask     = {PRE_W{1'b1}} >> shift;
  assign step         = tick_i && (pre_q == pre_mask);
  assign period_end_o = run_i && step && (cnt_q == '1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      pre_q    <= '0;
      cval_act <= '0;
      ps_act   <= '0;
    end else if (start_i) begin
      cnt_q    <= '0;
      pre_q    <= '0;
      cval_act <= cval_i;
      ps_act   <= ps_i;
    end else if (!run_i) begin
      cnt_q <= '0;
      pre_q <= '0;
    end else if (tick_i) begin
      if (step) begin
        pre_q <= '0;
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == '1) begin
          cval_act <= cval_i;
          ps_act   <= ps_i;
        end
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  assign active     = run_i && (cnt_q < cval_act);
  assign pwm_o      = active ? pol_i : ~pol_i;
  assign cnt_o      = cnt_q;
  assign cval_act_o = cval_act;
  assign ps_act_o   = ps_act;
endmodule

// File: rtl/bl_pwm.sv
`timescale 1ns/1ps
module bl_pwm
  import bl_pwm_pkg::*;
#(
  parameter int unsigned PS_LIMIT = PS_MAX,
  parameter int unsigned SYNC_N   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              slow_tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              pwm_o
);
  localparam int unsigned PRE_W = PS_LIMIT;

  logic [CNT_W-1:0] cval, cnt, cval_act;
  logic [PS_W-1:0]  ps, ps_act;
  logic             pol, fast, on, off;
  logic             tick, run, start, period_end;

  assign tick = fast ? 1'b1 : slow_tick_i;

  bl_pwm_regs #(.PS_LIMIT(PS_LIMIT)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .run_i   (run),
    .rdata_o (rdata_o),
    .cval_o  (cval),
    .ps_o    (ps),
    .pol_o   (pol),
    .fast_o  (fast),
    .on_o    (on),
    .off_o   (off)
  );

  bl_pwm_ctrl #(.SYNC_N(SYNC_N)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick),
    .on_i         (on),
    .off_i        (off),
    .period_end_i (period_end),
    .run_o        (run),
    .start_o      (start)
  );

  bl_pwm_core #(.CNT_W(CNT_W), .PS_W(PS_W), .PRE_W(PRE_W)) u_core (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick),
    .run_i        (run),
    .start_i      (start),
    .cval_i       (cval),
    .ps_i         (ps),
    .pol_i        (pol),
    .pwm_o        (pwm_o),
    .period_end_o (period_end),
    .cnt_o        (cnt),
    .cval_act_o   (cval_act),
    .ps_act_o     (ps_act)
  );
endmodule

// File: rtl/bl_pwm_chk.sv
`timescale 1ns/1ps
module bl_pwm_chk #(
  parameter int unsigned PS_LIMIT = 6,
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned PS_W     = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             run_i,
  input logic             pwm_i,
  input logic             pol_i,
  input logic             period_end_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [CNT_W-1:0] cval_act_i,
  input logic [PS_W-1:0]  ps_act_i
);
  assert_ps_cap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(ps_act_i) <= PS_LIMIT);

  assert_idle_level_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> (pwm_i == ~pol_i) && (cnt_i == '0));

  assert_zero_duty_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && cval_act_i == '0) |-> pwm_i == ~pol_i);

  assert_shadow_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !period_end_i) |=> $stable(cval_act_i) && $stable(ps_act_i));

  assert_stop_boundary_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(run_i) |-> $past(period_end_i));

  assert_start_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_i) |-> cnt_i == '0);
endmodule

bind bl_pwm bl_pwm_chk #(.PS_LIMIT(PS_LIMIT), .CNT_W(bl_pwm_pkg::CNT_W), .PS_W(bl_pwm_pkg::PS_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .run_i        (run),
  .pwm_i        (pwm_o),
  .pol_i        (pol),
  .period_end_i (period_end),
  .cnt_i        (cnt),
  .cval_act_i   (cval_act),
  .ps_act_i     (ps_act)
);

// File: tb/bl_pwm_tb.sv
`timescale 1ns/1ps
module bl_pwm_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slow_tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd3;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        pwm;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  int    q_win[$];
  int    q_tot[$];
  int    q_run[$];
  string q_tag[$];

  always #5 clk = ~clk;

  bl_pwm u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .slow_tick_i (slow_tick),
    .wr_en_i     (wr_en),
    .addr_i      (addr),
    .wdata_i     (wdata),
    .rdata_o     (rdata),
    .pwm_o       (pwm)
  );

  // slow reference: one tick every 8 clocks
  initial begin
    forever begin
      repeat (7) @(negedge clk);
      slow_tick = 1'b1;
      @(negedge clk);
      slow_tick = 1'b0;
    end
  end

  function automatic void check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endfunction

  function automatic logic [15:0] cfg(int cval, bit fast, bit pol, int ps);
    return {8'(cval), fast, 2'b00, pol, 1'b0, 3'(ps)};
  endfunction

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; addr = 2'd3;
    #1;
  endtask

  task automatic rd_cfg(output logic [15:0] v);
    @(negedge clk);
    addr = 2'd0;
    #1 v = rdata;
    addr = 2'd3;
    #1;
  endtask

  task automatic wait_status(input bit val, input int limit, input string tag);
    bit seen = 1'b0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (rdata[0] == val) begin seen = 1'b1; break; end
    end
    check(seen, tag, int'(rdata[0]), int'(val));
  endtask

  // driver side of the scoreboard
  task automatic expect_win(input int tot, input int run, input int win, input string tag);
    q_tot.push_back(tot); q_run.push_back(run); q_win.push_back(win); q_tag.push_back(tag);
  endtask

  task automatic wait_idle();
    wait (q_win.size() == 0);
  endtask

  // monitor: measures high count and longest high burst per window
  int m_tot, m_run, m_best;
  initial begin
    forever begin
      wait (q_win.size() > 0);
      m_tot = 0; m_run = 0; m_best = 0;
      for (int i = 0; i < q_win[0]; i++) begin
        @(negedge clk);
        if (pwm) begin
          m_tot++; m_run++;
          if (m_run > m_best) m_best = m_run;
        end else begin
          m_run = 0;
        end
      end
      check(m_tot == q_tot[0], {q_tag[0], " high count"}, m_tot, q_tot[0]);
      check(m_best == q_run[0], {q_tag[0], " burst"}, m_best, q_run[0]);
      void'(q_tot.pop_front()); void'(q_run.pop_front());
      void'(q_tag.pop_front()); void'(q_win.pop_front());
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(rdata[0] == 1'b0, "R6 status after reset", int'(rdata[0]), 0);
    check(pwm == 1'b0, "R8 idle output after reset", int'(pwm), 0);
    rd_cfg(v);
    check(v == 16'h0010, "R1 config reset value", int'(v), 16'h0010);

    wr(2'd0, cfg(200, 1, 1, 0));
    rd_cfg(v);
    check(v == 16'hC890, "R1 config readback", int'(v), 16'hC890);
    wr(2'd0, 16'hFFFF);
    rd_cfg(v);
    check(v == 16'hFF96, "R1 reserved bits read 0", int'(v), 16'hFF96);
    wr(2'd0, cfg(200, 1, 1, 7));
    rd_cfg(v);
    check(v == cfg(200, 1, 1, 6), "R2 prescaler 7 capped", int'(v), int'(cfg(200, 1, 1, 6)));
    wr(2'd0, cfg(200, 1, 1, 0));

    wr(2'd1, 16'h0000);
    repeat (20) @(negedge clk);
    #1;
    check(rdata[0] == 1'b0, "R6 zero write ignored", int'(rdata[0]), 0);
    check(pwm == 1'b0, "R6 zero write output idle", int'(pwm), 0);

    wr(2'd1, 16'h0001);
    check(rdata[0] == 1'b0, "R6 status not immediate", int'(rdata[0]), 0);
    wait_status(1'b1, 20, "R6 status rises");

    // first period measured from start; compare rewritten mid-period
    expect_win(200, 199, 256, "R9 old value holds");
    repeat (100) @(negedge clk);
    wr(2'd0, cfg(50, 1, 1, 0));
    wait_idle();
    expect_win(100, 50, 512, "R9 new value next period");
    wait_idle();

    wr(2'd0, cfg(0, 1, 1, 0));
    repeat (300) @(negedge clk);
    expect_win(0, 0, 512, "R10 compare zero");
    wait_idle();
    wr(2'd0, cfg(255, 1, 1, 0));
    repeat (300) @(negedge clk);
    expect_win(510, 255, 512, "R10 compare 255");
    wait_idle();

    wr(2'd0, cfg(64, 1, 1, 2));
    repeat (300) @(negedge clk);
    expect_win(512, 256, 2048, "R3 prescaler 2");
    wait_idle();

    wr(2'd0, cfg(64, 1, 0, 0));
    repeat (1100) @(negedge clk);
    expect_win(384, 192, 512, "R5 inverted polarity");
    wait_idle();

    wr(2'd2, 16'h0001);
    check(rdata[0] == 1'b1, "R7 status holds after stop request", int'(rdata[0]), 1);
    wait_status(1'b0, 400, "R7 status falls");
    #1;
    check(pwm == 1'b1, "R8 idle level with polarity 0", int'(pwm), 1);

    wr(2'd0, cfg(64, 0, 1, 0));
    check(pwm == 1'b0, "R8 idle level with polarity 1", int'(pwm), 0);
    wr(2'd1, 16'h0001);
    repeat (10) @(negedge clk);
    #1;
    check(rdata[0] == 1'b0, "R4 slow start delay", int'(rdata[0]), 0);
    wait_status(1'b1, 100, "R4 slow start completes");
    repeat (2200) @(negedge clk);
    expect_win(1024, 512, 4096, "R4 slow source");
    wait_idle();

    wr(2'd2, 16'h0001);
    check(rdata[0] == 1'b1, "R7 slow stop waits", int'(rdata[0]), 1);
    wait_status(1'b0, 3000, "R7 slow stop completes");
    expect_win(0, 0, 300, "R8 stopped output");
    wait_idle();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule